// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period End

A 16-bit up-counting timer that drives two pulse-width-modulated outputs. The counter starts at zero and counts up by one on each enabled clock. When it reaches the active end value (TOP), it returns to zero on the next enabled clock. TOP comes from one of five sources, picked by a select field: three fixed values (8, 9 or 10 bits wide), a period register, or the active value of compare channel A. So one register value can set both the pulse frequency and the resolution. The smallest useful TOP is 0x0003, which gives 2-bit resolution. The largest is 0xFFFF, which gives 16-bit resolution.

Each compare channel holds a value in a write buffer. The buffer is copied into the active comparator only when the counter reaches TOP, so a new duty cycle never tears a running period. The period register is not buffered. A write takes effect at once, so lowering it below the current count makes the counter run on to 0xFFFF and wrap before TOP can match again. Four sticky status flags record TOP, the two compare matches and a TOP taken from the period register. A write of one to a flag's bit clears that flag.

Software drives the block through a small write port. The counter value, the two output pins and the flags are visible as outputs. `en` gates counting and `rst` is a synchronous reset, active high.

Top module: `pwm_fast_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, all registers, all flags and both pins go to zero after that edge.
- R2: The select field, control bits [2:0], gives TOP as follows: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the period register (address 3), and 4 gives the active compare A value. Codes 5 to 7 give 0xFFFF.
- R3: When `en` is high, the counter increments by one each clock and goes to 0 on the clock after it equals TOP. When `en` is low, it holds its value.
- R4: On an enabled cycle with counter == TOP, flag bit 0 (overflow) is set after the edge. If TOP comes from the period register, flag bit 3 (capture) is set at the same edge. If TOP comes from compare A, flag bit 1 is set at the same edge.
- R5: On an enabled cycle where the counter equals channel A's active compare value, flag bit 1 is set. The same holds for channel B with flag bit 2.
- R6: Channel A's mode is control bits [4:3] and channel B's mode is bits [6:5]. In mode 2, the pin goes high when the counter returns to zero and goes low on the cycle after a compare match, so it is high for counts 0 through the compare value. Mode 3 gives the complement of mode 2. Modes 0 and 1 hold the pin low.
- R7: Compare A (address 1) and compare B (address 2) writes go to a buffer. The active value changes only at the edge where the counter leaves TOP.
- R8: A period register write takes effect at once. If the new TOP is below the current count, the counter runs on to 0xFFFF and wraps to 0 with no overflow flag. After that, it stops at the new TOP.
- R9: When the select field holds a fixed code (0 to 2), a compare write keeps only the bits within that TOP's width, and the bits above are zero.
- R10: Flags stay set until cleared. A write to address 4 clears each flag whose data bit is one, and leaves the others alone. A set event in the same cycle wins over the clear.
- R11: A channel whose active compare value is above TOP never matches. Its flag stays clear, and its pin stays at its bottom level for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 compare A, 2 compare B, 3 period, 4 flag clear |
| wr_data | input | 16 | Register write data |
| cnt | output | 16 | Current counter value |
| pwm_out | output | 2 | PWM pins, bit 0 channel A, bit 1 channel B |
| flags | output | 4 | Sticky flags: 0 overflow, 1 compare A, 2 compare B, 3 capture |

## Verification
The counter is run under each TOP source: two fixed widths, a reserved code, the period register and compare A. A wrap at the wrong value shows which source decode is wrong. Each channel is tried with compare values inside TOP, above TOP, and with masked high bits. Pin edges that come a period early tell a missing write buffer apart from a match that is off by one. The period register is lowered below the running count, so an immediate wrap is told apart from the required run-on to 0xFFFF. The flag-clear pattern clears some bits and not others, which separates per-bit clearing from a clear of the whole register.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_CH  = 2;
  localparam int ADDR_W  = 3;
  localparam int SEL_W   = 3;
  localparam int MODE_W  = 2;
  localparam int CTRL_W  = SEL_W + NUM_CH * MODE_W;
  localparam int FLAG_W  = NUM_CH + 2;
  localparam int F_OVF   = 0;
  localparam int F_CMP0  = 1;
  localparam int F_CAP   = NUM_CH + 1;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMP0   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PERIOD = 3'(1 + NUM_CH);
  localparam logic [ADDR_W-1:0] ADR_FCLR   = 3'(2 + NUM_CH);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_FIX8   = 3'd0,
    SEL_FIX9   = 3'd1,
    SEL_FIX10  = 3'd2,
    SEL_PERIOD = 3'd3,
    SEL_CMPA   = 3'd4
  } top_sel_e;

  localparam logic [MODE_W-1:0] MODE_NONINV = 2'b10;
  localparam logic [MODE_W-1:0] MODE_INV    = 2'b11;

  // Width mask of a fixed end value; also the fixed end value itself.
  function automatic cnt_t fixed_mask(input logic [SEL_W-1:0] sel);
    case (sel)
      SEL_FIX8:  return cnt_t'(16'h00FF);
      SEL_FIX9:  return cnt_t'(16'h01FF);
      SEL_FIX10: return cnt_t'(16'h03FF);
      default:   return '1;
    endcase
  endfunction

  function automatic cnt_t pick_top(input logic [SEL_W-1:0] sel,
                                    input cnt_t period, input cnt_t cmpa);
    case (sel)
      SEL_PERIOD: return period;
      SEL_CMPA:   return cmpa;
      default:    return fixed_mask(sel);
    endcase
  endfunction
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         top_hit,
  output logic         wrap
);
  assign top_hit = en && (cnt == top);
  assign wrap    = top_hit || (en && (cnt == {W{1'b1}}));

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (top_hit) cnt <= '0;
    else if (en)      cnt <= cnt + 1'b1;
  end

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    top_hit |=> (cnt == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
  a_r8_run_on: assert property (@(posedge clk) disable iff (rst)
    (en && (cnt > top)) |=> (cnt == $past(cnt + 1'b1)));
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (cnt == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] cnt,
  input  logic         wrap,
  input  logic         load,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic [1:0]   mode,
  output logic [W-1:0] cmp_act,
  output logic         match,
  output logic         pin
);
  import pwm_timer_pkg::*;

  logic [W-1:0] cmp_buf;
  logic         lvl;   // non-inverted waveform level

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr)   cmp_buf <= wr_val;
      if (load) cmp_act <= cmp_buf;
    end
  end

  assign match = en && (cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (rst)        lvl <= 1'b0;
    else if (wrap)  lvl <= 1'b1;
    else if (match) lvl <= 1'b0;
  end

  always_comb begin
    case (mode)
      MODE_NONINV: pin = lvl;
      MODE_INV:    pin = ~lvl;
      default:     pin = 1'b0;
    endcase
  end

  a_r7_buffer_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cmp_act == $past(cmp_buf)));
  a_r7_no_early_load: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cmp_act));
  a_r6_bottom_set: assert property (@(posedge clk) disable iff (rst)
    wrap |=> lvl);
  a_r6_match_clear: assert property (@(posedge clk) disable iff (rst)
    (match && !wrap) |=> !lvl);
  a_r11_level_hold: assert property (@(posedge clk) disable iff (rst)
    (!match && !wrap) |=> $stable(lvl));
endmodule

// File: rtl/pwm_fast_timer.sv
module pwm_fast_timer
  import pwm_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic [CNT_W-1:0]    cnt,
  output logic [NUM_CH-1:0]   pwm_out,
  output logic [FLAG_W-1:0]   flags
);
  logic [CTRL_W-1:0] ctrl;
  cnt_t              period;
  cnt_t              top;
  cnt_t              cmp_act [NUM_CH];
  logic [NUM_CH-1:0] match;
  logic              top_hit;
  logic              wrap;
  logic [SEL_W-1:0]  sel;
  cnt_t              wr_masked;
  logic [FLAG_W-1:0] flag_set;
  logic [FLAG_W-1:0] flag_clr;

  assign sel       = ctrl[SEL_W-1:0];
  assign top       = pick_top(sel, period, cmp_act[0]);
  assign wr_masked = wr_data & fixed_mask(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      period <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CTRL)   ctrl   <= wr_data[CTRL_W-1:0];
      if (wr_addr == ADR_PERIOD) period <= wr_data;
    end
  end

  pwm_counter #(.W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .en(en), .top(top),
    .cnt(cnt), .top_hit(top_hit), .wrap(wrap)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en && (wr_addr == ADDR_W'(ADR_CMP0 + i));
    pwm_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .en(en), .cnt(cnt), .wrap(wrap),
      .load(top_hit), .wr(ch_wr), .wr_val(wr_masked),
      .mode(ctrl[SEL_W + MODE_W*i +: MODE_W]),
      .cmp_act(cmp_act[i]), .match(match[i]), .pin(pwm_out[i])
    );
    assign flag_set[F_CMP0 + i] = match[i];
  end

  assign flag_set[F_OVF] = top_hit;
  assign flag_set[F_CAP] = top_hit && (sel == SEL_PERIOD);
  assign flag_clr = (wr_en && (wr_addr == ADR_FCLR)) ? wr_data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~flag_clr) | flag_set;
  end

  a_r4_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    top_hit |=> flags[F_OVF]);
  a_r4_cap_flag: assert property (@(posedge clk) disable iff (rst)
    (top_hit && (sel == SEL_PERIOD)) |=> flags[F_CAP]);
  a_r4_cmpa_with_ovf: assert property (@(posedge clk) disable iff (rst)
    (top_hit && (sel == SEL_CMPA)) |=> (flags[F_OVF] && flags[F_CMP0]));
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags[F_OVF] && !flag_clr[F_OVF]) |=> flags[F_OVF]);
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[F_OVF] && !top_hit) |=> !flags[F_OVF]);
  a_r1_reset_flags: assert property (@(posedge clk)
    rst |=> (flags == '0 && pwm_out == '0));
endmodule

// File: tb/test_pwm_fast_timer.sv
module test_pwm_fast_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt;
  logic [1:0]  pwm_out;
  logic [3:0]  flags;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  pwm_fast_timer i_pwm_fast_timer (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt(cnt), .pwm_out(pwm_out), .flags(flags)
  );

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cycles <= cycles + 1;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    wait (cycles >= 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
    finish_run();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int guard = 0;
    while (cnt !== v && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic t_reset();
    step(3);
    check(cnt == 0 && flags == 0 && pwm_out == 0, "R1 reset state",
          {cnt, 10'b0, pwm_out, flags}, 0);
    rst = 1'b0;
    en  = 1'b1;
  endtask

  task automatic t_fixed_top();
    wait_cnt(16'h00FF);
    step();
    check(cnt == 0, "R2/R3 wrap after 0x00FF", cnt, 0);
    check(flags[0] == 1'b1, "R4 overflow flag at TOP", flags, 1);
    check(flags[3] == 1'b0, "R4 capture flag clear with fixed TOP", flags[3], 0);
  endtask

  task automatic t_hold();
    logic [15:0] c;
    step(4);
    en = 1'b0;
    step();
    c = cnt;
    step(5);
    check(cnt == c, "R3 hold while disabled", cnt, c);
    en = 1'b1;
    step();
    check(cnt == c + 1, "R3 resume count", cnt, c + 1);
  endtask

  task automatic t_flags();
    step(20);
    check(flags[0] == 1'b1, "R10 overflow flag sticky", flags[0], 1);
    wait_cnt(16'h0040);
    wr(3'd4, 16'h0001);
    check(flags[0] == 1'b0 && flags[1] == 1'b1, "R10 partial clear", flags, 4'b0110);
    wr(3'd4, 16'h000F);
    check(flags == 4'b0000, "R10 full clear", flags, 0);
  endtask

  task automatic t_pwm();
    wr(3'd0, 16'h0070);          // fixed 8-bit TOP, A mode 2, B mode 3
    wr(3'd1, 16'h0010);
    wr(3'd2, 16'h0020);
    wait_cnt(16'h00FF);
    step();
    check(pwm_out[0] == 1'b1, "R6 mode 2 high at bottom", pwm_out[0], 1);
    check(pwm_out[1] == 1'b0, "R6 mode 3 low at bottom", pwm_out[1], 0);
    wr(3'd4, 16'h000F);
    wait_cnt(16'h0010);
    check(pwm_out[0] == 1'b1, "R6 mode 2 high at compare value", pwm_out[0], 1);
    step();
    check(pwm_out[0] == 1'b0, "R6 mode 2 low after match", pwm_out[0], 0);
    check(flags[1] == 1'b1 && flags[2] == 1'b0, "R5 compare A flag only", flags, 4'b0010);
    wait_cnt(16'h0020);
    check(pwm_out[1] == 1'b0, "R6 mode 3 low at compare value", pwm_out[1], 0);
    step();
    check(pwm_out[1] == 1'b1, "R6 mode 3 high after match", pwm_out[1], 1);
    check(flags[2] == 1'b1, "R5 compare B flag", flags[2], 1);
  endtask

  task automatic t_dbuf();
    wait_cnt(16'h0005);
    wr(3'd1, 16'h0040);
    wait_cnt(16'h0011);
    check(pwm_out[0] == 1'b0, "R7 old compare kept until TOP", pwm_out[0], 0);
    wait_cnt(16'h00FF);
    wait_cnt(16'h0011);
    check(pwm_out[0] == 1'b1, "R7 new compare after TOP, still high", pwm_out[0], 1);
    wait_cnt(16'h0041);
    check(pwm_out[0] == 1'b0, "R7 new compare takes effect", pwm_out[0], 0);
  endtask

  task automatic t_mask();
    wr(3'd0, 16'h0050);          // fixed 8-bit TOP, both mode 2
    wr(3'd2, 16'h1234);          // kept as 0x0034
    wait_cnt(16'h00FF);
    wait_cnt(16'h0034);
    check(pwm_out[1] == 1'b1, "R9 masked compare, high at 0x34", pwm_out[1], 1);
    step();
    check(pwm_out[1] == 1'b0, "R9 masked compare matches at 0x34", pwm_out[1], 0);
  endtask

  task automatic t_sel();
    wait_cnt(16'h0002);
    wr(3'd0, 16'h0051);          // fixed 9-bit TOP
    wait_cnt(16'h01FF);
    step();
    check(cnt == 0, "R2 wrap after 0x01FF", cnt, 0);
    wr(3'd0, 16'h0055);          // reserved code: TOP 0xFFFF
    wait_cnt(16'h0400);
    check(cnt == 16'h0400, "R2 reserved code passes fixed values", cnt, 16'h0400);
    wr(3'd3, 16'h0500);
    wr(3'd0, 16'h0053);          // period register TOP
    wr(3'd4, 16'h000F);
    wait_cnt(16'h0500);
    step();
    check(cnt == 0, "R2 wrap at period value", cnt, 0);
    check(flags[0] == 1'b1 && flags[3] == 1'b1, "R4 capture and overflow flags",
          flags, 4'b1001);
  endtask

  task automatic t_period_low();
    wait_cnt(16'h0050);
    wr(3'd3, 16'h0010);
    wr(3'd4, 16'h000F);
    wait_cnt(16'hFFFF);
    check(cnt == 16'hFFFF, "R8 run on to 0xFFFF", cnt, 16'hFFFF);
    check(flags[0] == 1'b0, "R8 no overflow during run-on", flags[0], 0);
    step();
    check(cnt == 0, "R8 wrap from 0xFFFF", cnt, 0);
    wait_cnt(16'h0010);
    step();
    check(cnt == 0 && flags[0] == 1'b1, "R8 new period used after wrap",
          {cnt, 12'b0, flags}, 1);
  endtask

  task automatic t_above_top();
    bit ok = 1'b1;
    logic [1:0] bad = '0;
    wait_cnt(16'h0005);
    wr(3'd4, 16'h000F);
    for (int i = 0; i < 40; i++) begin
      if (pwm_out[1] !== 1'b1 || flags[2] !== 1'b0) begin
        ok = 1'b0;
        bad = {pwm_out[1], flags[2]};
      end
      step();
    end
    check(ok, "R11 compare above TOP never matches", bad, 2'b10);
  endtask

  task automatic t_cmpa_top();
    wr(3'd1, 16'h0030);
    wait_cnt(16'h0010);
    wait_cnt(16'h0002);
    wr(3'd0, 16'h0054);          // compare A defines TOP
    wr(3'd4, 16'h000F);
    wait_cnt(16'h0030);
    step();
    check(cnt == 0, "R2 wrap at compare A value", cnt, 0);
    check(flags[0] && flags[1] && !flags[3], "R4 compare A flag with overflow",
          flags, 4'b0011);
  endtask

  task automatic t_mode_off();
    bit ok = 1'b1;
    wr(3'd0, 16'h0004);
    for (int i = 0; i < 60; i++) begin
      if (pwm_out !== 2'b00) ok = 1'b0;
      step();
    end
    check(ok, "R6 modes 0/1 hold pins low", pwm_out, 0);
  endtask

  initial begin
    step();
    t_reset();
    t_fixed_top();
    t_hold();
    t_flags();
    t_pwm();
    t_dbuf();
    t_mask();
    t_sel();
    t_period_low();
    t_above_top();
    t_cmpa_top();
    t_mode_off();
    finish_run();
  end
endmodule